// File: doc/BRIEF.md
# Dual-Buffer DMA Channel Sequencer

This block runs a single DMA channel that copies 32-bit words from a read-side bus to a write-side bus. Software describes work in two buffer descriptor sets, numbered 0 and 1. Each set has a source address, a destination address, a byte length and an enable bit. The sequencer serves the enabled sets in turn. For each word it issues a read request, holds the returned data, and then issues a write request. The bus engines themselves are outside the block. Each side is reduced to a request line with an acknowledge and an error input.

An error ends only the set that was running. A read-side fatal error covers master abort, target abort, ready-wait timeout and retry timeout. A read-side fatal error and a write-side error response are recorded in separate global status bits. In either case the failing set is marked done and in error. The other set, if enabled, is still served and runs to completion. Every set that ends, whether cleanly or by error, raises a channel-level done interrupt bit. All flags are cleared by writing 1 to them.

Top module: `dds_top`

## Requirements
- R1: After reset, all enables, done flags, error flags, the interrupt bit, both fatal bits, `rd_req`, `wr_req` and `busy` are 0.
- R2: A `desc_load` pulse with a nonzero length stores source, destination and length into set `desc_sel` and sets its enable. A load with zero length is ignored. A load aimed at the set currently being served is ignored.
- R3: Each beat raises `rd_req` at the current source address. The data returned with `rd_ack` is then written with `wr_req` at the current destination address. Each acknowledged write advances both addresses by 4 and reduces the length by 4. The set ends when the length reaches 0.
- R4: A set that ends without error sets its done flag, leaves its error flag clear, clears its enable and sets `chan_irq`.
- R5: Sets are chosen in alternation. Set 0 goes first after reset. After a set ends, the other set is chosen next if it is enabled. A set whose enable is clear is skipped.
- R6: `rd_err` during a read request ends the set with no write for that beat. It sets the set's done and error flags, clears its enable, and sets `chan_irq` and `rd_fatal`, but not `wr_fatal`.
- R7: `wr_err` during a write request ends the set. It sets the set's done and error flags, clears its enable, and sets `chan_irq` and `wr_fatal`, but not `rd_fatal`.
- R8: An error on one set leaves the other enabled set running normally to completion, with its error flag clear.
- R9: Each clear input is write-1-to-clear and affects only the bits it names. A flag set in the same cycle wins over its clear.
- R10: `rd_req` and `wr_req` are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| desc_load | input | 1 | Load pulse for one descriptor set |
| desc_sel | input | 1 | Set written by `desc_load` |
| desc_src | input | AW | Source start address |
| desc_dst | input | AW | Destination start address |
| desc_len | input | LW | Length in bytes, multiple of 4 |
| clr_done | input | 2 | Write-1-to-clear per-set done flags |
| clr_err | input | 2 | Write-1-to-clear per-set error flags |
| clr_irq | input | 1 | Write-1-to-clear channel interrupt bit |
| clr_rd_fatal | input | 1 | Write-1-to-clear read fatal bit |
| clr_wr_fatal | input | 1 | Write-1-to-clear write error bit |
| rd_req | output | 1 | Read request |
| rd_addr | output | AW | Read address |
| rd_ack | input | 1 | Read completion, data valid |
| rd_data | input | DW | Read data |
| rd_err | input | 1 | Read-side fatal error |
| wr_req | output | 1 | Write request |
| wr_addr | output | AW | Write address |
| wr_data | output | DW | Write data |
| wr_ack | input | 1 | Write accepted |
| wr_err | input | 1 | Write-side error response |
| set_en | output | 2 | Per-set enable bits |
| set_done | output | 2 | Per-set done flags |
| set_err | output | 2 | Per-set error flags |
| chan_irq | output | 1 | Channel done interrupt bit |
| rd_fatal | output | 1 | Read-side fatal status |
| wr_fatal | output | 1 | Write-side error status |
| busy | output | 1 | A set is being served |

## Verification
After a load, the set's enable rises one edge later. The read request appears one edge after that. Each read acknowledge sampled at an edge turns into a write request one cycle later. Flags, enable and interrupt change on the same edge that samples the last write acknowledge or an error. The bench drives inputs and answers requests on the falling edge, so every response is seen by the next rising edge. The scoreboard compares each write address and data word in the cycle where `wr_req` is high. Flag checks run only once `busy` and both enables read low, which is already after the closing edge.

// File: rtl/dds_pkg.sv
package dds_pkg;

  localparam int NSETS = 2;
  localparam int BEAT_BYTES = 4;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_RD   = 2'd1,
    ST_WR   = 2'd2
  } st_e;

  // address of the next word
  function automatic logic [63:0] addr_next(input logic [63:0] a);
    return a + 64'(BEAT_BYTES);
  endfunction

  // remaining length after one beat, floored at zero
  function automatic logic [63:0] len_next(input logic [63:0] l);
    return (l > 64'(BEAT_BYTES)) ? l - 64'(BEAT_BYTES) : 64'd0;
  endfunction

  // the current beat is the final one of the set
  function automatic logic len_last(input logic [63:0] l);
    return l <= 64'(BEAT_BYTES);
  endfunction

endpackage

// File: rtl/dds_desc.sv
module dds_desc #(
  parameter int AW = 32,
  parameter int LW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [AW-1:0] ld_src,
  input  logic [AW-1:0] ld_dst,
  input  logic [LW-1:0] ld_len,
  input  logic          step,
  input  logic          retire,
  output logic [AW-1:0] src,
  output logic [AW-1:0] dst,
  output logic [LW-1:0] len,
  output logic          en
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      src <= '0;
      dst <= '0;
      len <= '0;
      en  <= 1'b0;
    end else begin
      if (load) begin
        src <= ld_src;
        dst <= ld_dst;
        len <= ld_len;
      end else if (step) begin
        src <= AW'(dds_pkg::addr_next(64'(src)));
        dst <= AW'(dds_pkg::addr_next(64'(dst)));
        len <= LW'(dds_pkg::len_next(64'(len)));
      end
      if (retire)    en <= 1'b0;
      else if (load) en <= 1'b1;
    end
  end
endmodule

// File: rtl/dds_pick.sv
module dds_pick (
  input  logic [1:0] en,
  input  logic       pref,
  output logic       valid,
  output logic       sel
);
  always_comb begin
    valid = 1'b0;
    sel   = pref;
    if (en[pref]) begin
      valid = 1'b1;
      sel   = pref;
    end else if (en[~pref]) begin
      valid = 1'b1;
      sel   = ~pref;
    end
  end
endmodule

// File: rtl/dds_top.sv
module dds_top #(
  parameter int AW = 32,
  parameter int DW = 32,
  parameter int LW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          desc_load,
  input  logic          desc_sel,
  input  logic [AW-1:0] desc_src,
  input  logic [AW-1:0] desc_dst,
  input  logic [LW-1:0] desc_len,
  input  logic [1:0]    clr_done,
  input  logic [1:0]    clr_err,
  input  logic          clr_irq,
  input  logic          clr_rd_fatal,
  input  logic          clr_wr_fatal,
  output logic          rd_req,
  output logic [AW-1:0] rd_addr,
  input  logic          rd_ack,
  input  logic [DW-1:0] rd_data,
  input  logic          rd_err,
  output logic          wr_req,
  output logic [AW-1:0] wr_addr,
  output logic [DW-1:0] wr_data,
  input  logic          wr_ack,
  input  logic          wr_err,
  output logic [1:0]    set_en,
  output logic [1:0]    set_done,
  output logic [1:0]    set_err,
  output logic          chan_irq,
  output logic          rd_fatal,
  output logic          wr_fatal,
  output logic          busy
);
  import dds_pkg::*;

  st_e           st;
  logic          act;
  logic          pref;
  logic [DW-1:0] rdata_q;

  logic [AW-1:0] src_w [NSETS];
  logic [AW-1:0] dst_w [NSETS];
  logic [LW-1:0] len_w [NSETS];
  logic [NSETS-1:0] load_w, step_w, retire_w;

  logic pick_valid, pick_sel;

  // named internal events
  logic beat_ok, last_beat, end_ok, end_rd, end_wr, end_bad, end_any;

  assign busy    = (st != ST_IDLE);
  assign rd_req  = (st == ST_RD);
  assign wr_req  = (st == ST_WR);
  assign rd_addr = src_w[act];
  assign wr_addr = dst_w[act];
  assign wr_data = rdata_q;

  assign last_beat = len_last(64'(len_w[act]));
  assign beat_ok   = wr_req && wr_ack && !wr_err;
  assign end_ok    = beat_ok && last_beat;
  assign end_rd    = rd_req && rd_err;
  assign end_wr    = wr_req && wr_err;
  assign end_bad   = end_rd || end_wr;
  assign end_any   = end_ok || end_bad;

  dds_pick u_pick (
    .en    (set_en),
    .pref  (pref),
    .valid (pick_valid),
    .sel   (pick_sel)
  );

  for (genvar i = 0; i < NSETS; i++) begin : g_set
    assign load_w[i]   = desc_load && (desc_sel == 1'(i)) && (desc_len != '0)
                         && !(busy && act == 1'(i));
    assign step_w[i]   = beat_ok && (act == 1'(i));
    assign retire_w[i] = end_any && (act == 1'(i));

    dds_desc #(.AW(AW), .LW(LW)) u_desc (
      .clk    (clk),
      .rst_n  (rst_n),
      .load   (load_w[i]),
      .ld_src (desc_src),
      .ld_dst (desc_dst),
      .ld_len (desc_len),
      .step   (step_w[i]),
      .retire (retire_w[i]),
      .src    (src_w[i]),
      .dst    (dst_w[i]),
      .len    (len_w[i]),
      .en     (set_en[i])
    );

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        set_done[i] <= 1'b0;
        set_err[i]  <= 1'b0;
      end else begin
        set_done[i] <= (set_done[i] & ~clr_done[i]) | retire_w[i];
        set_err[i]  <= (set_err[i] & ~clr_err[i]) | (retire_w[i] & end_bad);
      end
    end

    assert_retire_clears_en_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (end_any && act == 1'(i)) |=> !set_en[i]);
    assert_err_has_done_R6: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(set_err[i]) |-> set_done[i]);
  end

  // sequencing state machine
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st      <= ST_IDLE;
      act     <= 1'b0;
      pref    <= 1'b0;
      rdata_q <= '0;
    end else begin
      case (st)
        ST_IDLE: if (pick_valid) begin
          act <= pick_sel;
          st  <= ST_RD;
        end
        ST_RD: if (rd_err) st <= ST_IDLE;
          else if (rd_ack) begin
            rdata_q <= rd_data;
            st      <= ST_WR;
          end
        ST_WR: if (wr_err) st <= ST_IDLE;
          else if (wr_ack) st <= last_beat ? ST_IDLE : ST_RD;
        default: st <= ST_IDLE;
      endcase
      if (end_any) pref <= ~act;
    end
  end

  // channel and global status bits
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      chan_irq <= 1'b0;
      rd_fatal <= 1'b0;
      wr_fatal <= 1'b0;
    end else begin
      chan_irq <= (chan_irq & ~clr_irq) | end_any;
      rd_fatal <= (rd_fatal & ~clr_rd_fatal) | end_rd;
      wr_fatal <= (wr_fatal & ~clr_wr_fatal) | end_wr;
    end
  end

  assert_req_excl_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !(rd_req && wr_req));
  assert_addr_step_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (beat_ok && !last_beat) |=> (rd_req && rd_addr == $past(rd_addr) + AW'(4)));
  assert_rd_fatal_cause_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rd_fatal) |-> $past(rd_req && rd_err));
  assert_wr_fatal_cause_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(wr_fatal) |-> $past(wr_req && wr_err));
  assert_irq_cause_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(chan_irq) |-> $past(end_any));

endmodule

// File: tb/sim_dds_top.sv
module sim_dds_top;
  localparam int AW = 32;
  localparam int DW = 32;
  localparam int LW = 16;
  localparam logic [31:0] KEY  = 32'hC3C3_0000;
  localparam logic [31:0] NONE = 32'hFFFF_FFFF;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #5 clk = ~clk;

  logic          desc_load = 0, desc_sel = 0;
  logic [AW-1:0] desc_src = 0, desc_dst = 0;
  logic [LW-1:0] desc_len = 0;
  logic [1:0]    clr_done = 0, clr_err = 0;
  logic          clr_irq = 0, clr_rd_fatal = 0, clr_wr_fatal = 0;
  logic          rd_req, wr_req, rd_ack = 0, rd_err = 0, wr_ack = 0, wr_err = 0;
  logic [AW-1:0] rd_addr, wr_addr;
  logic [DW-1:0] rd_data = 0, wr_data;
  logic [1:0]    set_en, set_done, set_err;
  logic          chan_irq, rd_fatal, wr_fatal, busy;

  dds_top #(.AW(AW), .DW(DW), .LW(LW)) u0 (
    .clk(clk), .rst_n(rst_n), .desc_load(desc_load), .desc_sel(desc_sel),
    .desc_src(desc_src), .desc_dst(desc_dst), .desc_len(desc_len),
    .clr_done(clr_done), .clr_err(clr_err), .clr_irq(clr_irq),
    .clr_rd_fatal(clr_rd_fatal), .clr_wr_fatal(clr_wr_fatal),
    .rd_req(rd_req), .rd_addr(rd_addr), .rd_ack(rd_ack), .rd_data(rd_data),
    .rd_err(rd_err), .wr_req(wr_req), .wr_addr(wr_addr), .wr_data(wr_data),
    .wr_ack(wr_ack), .wr_err(wr_err), .set_en(set_en), .set_done(set_done),
    .set_err(set_err), .chan_irq(chan_irq), .rd_fatal(rd_fatal),
    .wr_fatal(wr_fatal), .busy(busy)
  );

  int n_run = 0, n_fail = 0;
  logic [63:0] exp_q[$];
  logic [31:0] rd_fail_at = NONE, wr_fail_at = NONE;

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // bus responders and scoreboard monitor
  always @(negedge clk) begin
    rd_ack <= 0; rd_err <= 0; wr_ack <= 0; wr_err <= 0;
    if (rst_n && rd_req) begin
      if (rd_addr == rd_fail_at) rd_err <= 1;
      else begin rd_ack <= 1; rd_data <= rd_addr ^ KEY; end
    end
    if (rst_n && wr_req) begin
      if (exp_q.size() == 0) check("R3 unexpected write", {wr_addr, wr_data}, 64'hX);
      else check("R3 write beat", {wr_addr, wr_data}, exp_q.pop_front());
      if (wr_addr == wr_fail_at) wr_err <= 1;
      else wr_ack <= 1;
    end
  end

  // driver: load a set and push the writes it must produce
  task automatic arm(input logic s, input logic [31:0] src, input logic [31:0] dst,
                     input int len, input int nexp);
    for (int k = 0; k < nexp; k++)
      exp_q.push_back({dst + 32'(4*k), (src + 32'(4*k)) ^ KEY});
    @(negedge clk);
    desc_load = 1; desc_sel = s; desc_src = src; desc_dst = dst; desc_len = LW'(len);
    @(negedge clk);
    desc_load = 0;
  endtask

  task automatic wait_idle();
    for (int k = 0; k < 400; k++) begin
      @(negedge clk);
      if (!busy && set_en == 2'b00) break;
    end
    repeat (2) @(negedge clk);
    check("R3 queue drained", 64'(exp_q.size()), 64'd0);
  endtask

  task automatic clear_all();
    @(negedge clk);
    clr_done = 2'b11; clr_err = 2'b11; clr_irq = 1; clr_rd_fatal = 1; clr_wr_fatal = 1;
    @(negedge clk);
    clr_done = 0; clr_err = 0; clr_irq = 0; clr_rd_fatal = 0; clr_wr_fatal = 0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1 reset state
    check("R1 reset flags", {set_en, set_done, set_err, chan_irq, rd_fatal, wr_fatal},
          64'd0);
    check("R1 reset requests", {rd_req, wr_req, busy}, 64'd0);

    // R2 R3 R4: single set 0, three beats
    arm(0, 32'h0000_1000, 32'h0000_8000, 12, 3);
    wait_idle();
    check("R4 done/err/en/irq", {set_done, set_err, set_en, chan_irq}, {2'b01, 2'b00, 2'b00, 1'b1});

    // R9 clear only done of set 0, irq stays
    @(negedge clk); clr_done = 2'b01; @(negedge clk); clr_done = 0;
    check("R9 partial clear", {set_done, chan_irq}, {2'b00, 1'b1});
    clear_all();
    check("R9 full clear", {set_done, set_err, chan_irq, rd_fatal, wr_fatal}, 64'd0);

    // R5: both sets, set 0 then set 1
    arm(0, 32'h0000_2000, 32'h0000_A000, 8, 2);
    arm(1, 32'h0000_3000, 32'h0000_B000, 16, 4);
    wait_idle();
    check("R5 both done clean", {set_done, set_err, chan_irq}, {2'b11, 2'b00, 1'b1});
    clear_all();

    // R6 R8: read error on set 0 beat 2, set 1 still completes
    rd_fail_at = 32'h0000_4008;
    arm(0, 32'h0000_4000, 32'h0000_C000, 16, 2);
    arm(1, 32'h0000_5000, 32'h0000_D000, 8, 2);
    wait_idle();
    check("R6 read error flags", {set_done, set_err, rd_fatal, wr_fatal, chan_irq},
          {2'b11, 2'b01, 1'b1, 1'b0, 1'b1});
    check("R8 other set clean", 64'(set_err[1]), 64'd0);
    rd_fail_at = NONE;
    clear_all();

    // R7 R5 R8: set 1 alone first (set 0 skipped), write error at beat 1
    wr_fail_at = 32'h0000_9004;
    arm(1, 32'h0000_6000, 32'h0000_9000, 12, 2);
    arm(0, 32'h0000_7000, 32'h0000_E000, 8, 2);
    wait_idle();
    check("R7 write error flags", {set_done, set_err, rd_fatal, wr_fatal, chan_irq},
          {2'b11, 2'b10, 1'b0, 1'b1, 1'b1});
    check("R8 set 0 clean", 64'(set_err[0]), 64'd0);
    wr_fail_at = NONE;
    clear_all();

    // R2 zero-length load ignored
    arm(1, 32'h0000_0100, 32'h0000_0200, 0, 0);
    repeat (3) @(negedge clk);
    check("R2 zero length ignored", {set_en, busy, rd_req}, 64'd0);

    // R2 load aimed at the active set ignored
    arm(0, 32'h0000_F000, 32'h0001_0000, 16, 4);
    repeat (2) @(negedge clk);
    check("R2 busy before reload", 64'(busy), 64'd1);
    @(negedge clk);
    desc_load = 1; desc_sel = 0; desc_src = 32'h0000_0400; desc_dst = 32'h0000_0500;
    desc_len = 16'd8;
    @(negedge clk);
    desc_load = 0;
    wait_idle();
    check("R2 active reload ignored", {set_en, set_done, set_err}, {2'b00, 2'b01, 2'b00});

    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule